// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per qualified clock using a left-shifting register whose width equals the degree of the divisor polynomial. The feedback from the most significant cell is XORed into each cell whose divisor coefficient is 1. Cell 0 always has a tap and receives the incoming bit. The divisor's low-order coefficients are a synthesis parameter, so one source covers 4-, 5-, 12- and 16-bit check sequences.

In generate mode the block performs plain modulo-2 long division of the message multiplied by x^W. Here W is the register width. The message enters most significant bit first. It is followed by W padding slots, which are always taken as zero whatever the serial input carries. After the frame the register holds the check sequence, ready to append after the data. In check mode the same datapath takes a whole received frame, data then check sequence. A nonzero final remainder raises the error flag. A frame-length counter marks completion with a one-cycle pulse. After that the register holds its value until the next synchronous clear.

Top module: `crc_serial_unit`

## Requirements
- R1: After rst_n low, or in the cycle after clr is high, rem_out is 0, done is 0 and crc_err is 0. clr wins over a qualified bit in the same cycle.
- R2: The register advances only on cycles where in_valid is 1. With in_valid at 0, rem_out stays unchanged whatever in_bit is. During a frame, rem_out equals the modulo-2 remainder of the bits accepted so far, read as a polynomial with the first bit as the highest power, divided by P.
- R3: With mode = 0 (generate), after MSG_BITS + FCS_W qualified bits rem_out equals the remainder of message·x^FCS_W divided by P. For P = 110101 and message 1010001101 (first bit leftmost), the result is 01110.
- R4: In generate mode, the in_bit value of the last FCS_W qualified bits of a frame is ignored and treated as 0.
- R5: With mode = 1 (check), after MSG_BITS + FCS_W qualified bits rem_out is the remainder of the whole frame divided by P. crc_err is 1 exactly when that remainder is nonzero. In generate mode crc_err stays 0. The frame 101000110101110 gives a zero remainder.
- R6: done is high for exactly one cycle, the cycle right after the edge that accepts the last bit of a frame. crc_err is valid from that cycle and holds until clr.
- R7: Once a frame is complete, further qualified bits are ignored. rem_out and crc_err hold until clr.
- R8: With FCS_W = 4 and P = 11001, message 00111011001 yields 0100. Checking that codeword with any single bit inverted gives a nonzero remainder and crc_err = 1.
- R9: With FCS_W = 16 and low coefficients 0x1021 (x^16+x^12+x^5+1), generate and check results match modulo-2 division for arbitrary 24-bit messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of register, counter and flags |
| mode | input | 1 | 0 = generate, 1 = check; held steady during a frame |
| in_valid | input | 1 | Qualifies in_bit in this cycle |
| in_bit | input | 1 | Serial data, first bit = highest polynomial power |
| rem_out | output | FCS_W | Current register contents, the check sequence or remainder at frame end |
| done | output | 1 | One-cycle pulse after the last bit of a frame |
| crc_err | output | 1 | Nonzero remainder found in check mode |

## Verification
Directed frames use both small divisors: the published codewords, a check of each valid codeword, and every single-bit corruption of the 4-bit codeword. Together these separate a correct tap placement from a shifted or missing tap. Generate frames are sent once with zero padding and once with random padding, which shows whether padding slots are really forced to zero. Random messages with random idle gaps run on the 5-bit and 16-bit instances, in both modes. Clean and corrupted frames are mixed, so the error flag is compared against a zero and a nonzero remainder, and input qualification is exercised mid-frame. Bits sent after a completed frame and a clear asserted during a frame probe the hold and clear behaviour.

// File: rtl/crc_pkg.sv
package crc_pkg;
   typedef enum logic {
      CRC_GEN = 1'b0,
      CRC_CHK = 1'b1
   } crc_mode_e;
endpackage

// File: rtl/crc_divider.sv
// Shift-register divider: cell 0 takes the serial bit XOR feedback, every
// other cell takes its lower neighbour, XORed with feedback where tapped.
module crc_divider #(
   parameter int          W    = 5,
   parameter logic [63:0] POLY = 64'h15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] rem,
   output logic [W-1:0] rem_next
);
   logic [W-1:0] cells;
   logic         fb;

   assign fb = cells[W-1];

   for (genvar i = 0; i < W; i++) begin : g_cell
      if (i == 0) begin : g_entry
         assign rem_next[0] = din ^ fb;
      end else if (POLY[i]) begin : g_tap
         assign rem_next[i] = cells[i-1] ^ fb;
      end else begin : g_wire
         assign rem_next[i] = cells[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (clr) begin
         cells <= '0;
      end else if (shift_en) begin
         cells <= rem_next;
      end
   end

   assign rem = cells;
endmodule

// File: rtl/crc_frame_ctl.sv
// Counts qualified bits of one frame, flags the padding slots, closes the frame.
module crc_frame_ctl #(
   parameter int MSG_BITS = 10,
   parameter int N_BITS   = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic in_valid,
   input  logic gen_mode,
   output logic take,
   output logic pad_phase,
   output logic last,
   output logic done
);
   localparam int             CW       = $clog2(N_BITS + 1);
   localparam logic [CW-1:0]  LAST_IDX = CW'(N_BITS - 1);
   localparam logic [CW-1:0]  PAD_IDX  = CW'(MSG_BITS);

   logic [CW-1:0] cnt;
   logic          full;

   assign take      = in_valid & ~full & ~clr;
   assign last      = take && (cnt == LAST_IDX);
   assign pad_phase = gen_mode && (cnt >= PAD_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         full <= 1'b0;
         done <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         full <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (last) begin
            cnt  <= '0;
            full <= 1'b1;
         end else if (take) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
   parameter int          FCS_W    = 5,
   parameter logic [63:0] POLY     = 64'h15,
   parameter int          MSG_BITS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             mode,
   input  logic             in_valid,
   input  logic             in_bit,
   output logic [FCS_W-1:0] rem_out,
   output logic             done,
   output logic             crc_err
);
   import crc_pkg::*;

   localparam int N_BITS = MSG_BITS + FCS_W;

   if (FCS_W < 1 || FCS_W > 64) begin : g_bad_width
      $error("crc_serial_unit: FCS_W must lie in 1..64");
   end
   if (MSG_BITS < 1) begin : g_bad_msg
      $error("crc_serial_unit: MSG_BITS must be at least 1");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc_serial_unit: divisor must end with a 1 coefficient");
   end

   logic             take, pad_phase, last;
   logic             gen_mode, chk_mode;
   logic             data_bit;
   logic [FCS_W-1:0] rem_next;

   assign gen_mode = (crc_mode_e'(mode) == CRC_GEN);
   assign chk_mode = (crc_mode_e'(mode) == CRC_CHK);
   assign data_bit = pad_phase ? 1'b0 : in_bit;

   crc_frame_ctl #(
      .MSG_BITS (MSG_BITS),
      .N_BITS   (N_BITS)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .in_valid  (in_valid),
      .gen_mode  (gen_mode),
      .take      (take),
      .pad_phase (pad_phase),
      .last      (last),
      .done      (done)
   );

   crc_divider #(
      .W    (FCS_W),
      .POLY (POLY)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .shift_en (take),
      .din      (data_bit),
      .rem      (rem_out),
      .rem_next (rem_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_err <= 1'b0;
      end else if (clr) begin
         crc_err <= 1'b0;
      end else if (last) begin
         crc_err <= chk_mode && (rem_next != '0);
      end
   end
endmodule

// File: rtl/crc_serial_unit_chk.sv
module crc_serial_unit_chk #(
   parameter int W = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         mode,
   input logic         in_valid,
   input logic [W-1:0] rem_out,
   input logic         done,
   input logic         crc_err
);
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rem_out == '0 && !done && !crc_err)); // R1
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clr) |=> $stable(rem_out)); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err && !clr) |=> crc_err); // R6
   AST_ERR_GEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(mode)) |-> !crc_err); // R5
   AST_ERR_FROM_REM: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mode)) |-> (crc_err == (rem_out != '0))); // R5
endmodule

bind crc_serial_unit crc_serial_unit_chk #(.W(FCS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .mode     (mode),
   .in_valid (in_valid),
   .rem_out  (rem_out),
   .done     (done),
   .crc_err  (crc_err)
);

// File: tb/test_crc_serial_unit.sv
`timescale 1ns/1ps
module test_crc_serial_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, mode = 1'b0, bitin = 1'b0;
   logic v5 = 1'b0, v4 = 1'b0, v16 = 1'b0;
   logic [4:0]  r5;  logic d5, e5;
   logic [3:0]  r4;  logic d4, e4;
   logic [15:0] r16; logic d16, e16;
   int checks = 0, failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   crc_serial_unit #(.FCS_W(5), .POLY(64'h15), .MSG_BITS(10)) i_crc_serial_unit (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .in_valid(v5), .in_bit(bitin),
      .rem_out(r5), .done(d5), .crc_err(e5));
   crc_serial_unit #(.FCS_W(4), .POLY(64'h9), .MSG_BITS(11)) i_crc_serial_unit_w4 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .in_valid(v4), .in_bit(bitin),
      .rem_out(r4), .done(d4), .crc_err(e4));
   crc_serial_unit #(.FCS_W(16), .POLY(64'h1021), .MSG_BITS(24)) i_crc_serial_unit_w16 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .in_valid(v16), .in_bit(bitin),
      .rem_out(r16), .done(d16), .crc_err(e16));

   function automatic logic [15:0] mod2rem(logic [63:0] bits, int len, int w, logic [16:0] pf);
      logic [16:0] acc = '0;
      for (int i = len - 1; i >= 0; i--) begin
         acc = {acc[15:0], bits[i]};
         if (acc[w]) acc = acc ^ pf;
      end
      return acc[15:0];
   endfunction

   function automatic logic [15:0] get_rem(int u);
      case (u) 0: return 16'(r5); 1: return 16'(r4); default: return r16; endcase
   endfunction
   function automatic logic get_done(int u);
      case (u) 0: return d5; 1: return d4; default: return d16; endcase
   endfunction
   function automatic logic get_err(int u);
      case (u) 0: return e5; 1: return e4; default: return e16; endcase
   endfunction

   task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic set_valid(int u, logic v);
      v5 = (u == 0) ? v : 1'b0;
      v4 = (u == 1) ? v : 1'b0;
      v16 = (u == 2) ? v : 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   // Sends len bits, first bits[len-1]; returns at the negedge where done is high.
   task automatic send(int u, logic [63:0] bits, int len, logic md, bit gaps, bit rnd_pad, int k);
      @(negedge clk); mode = md;
      for (int i = len - 1; i >= 0; i--) begin
         if (gaps) begin
            while ($urandom % 3 == 0) begin
               set_valid(u, 1'b0); bitin = 1'($urandom); @(negedge clk);
            end
         end
         set_valid(u, 1'b1);
         bitin = (rnd_pad && (len - 1 - i) >= k) ? 1'($urandom) : bits[i];
         @(negedge clk);
      end
      set_valid(u, 1'b0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] fr;
      logic [15:0] exp;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_eq("R1", "reset rem", 64'(r5), 0);
      check_eq("R1", "reset done/err", {d5, e5}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 directed vector, zero padding
      send(0, 64'b1010001101 << 5, 15, 1'b0, 0, 0, 10);
      check_eq("R3", "fcs 110101", 64'(r5), 64'b01110);
      check_eq("R6", "done pulse", 64'(d5), 1);
      check_eq("R5", "gen mode err", 64'(e5), 0);
      @(negedge clk);
      check_eq("R6", "done drops", 64'(d5), 0);
      // R7 extra bits after completion
      send(0, 64'b111, 3, 1'b0, 0, 0, 99);
      check_eq("R7", "hold after frame", 64'(r5), 64'b01110);
      check_eq("R7", "no second done", 64'(d5), 0);

      // R4 random padding ignored
      do_clr();
      check_eq("R1", "clr empties", 64'(r5), 0);
      send(0, 64'b1010001101 << 5, 15, 1'b0, 0, 1, 10);
      check_eq("R4", "random pad", 64'(r5), 64'b01110);

      // R5 check the codeword, then a corrupted one
      do_clr();
      send(0, 64'b101000110101110, 15, 1'b1, 1, 0, 99);
      check_eq("R5", "clean rem", 64'(r5), 0);
      check_eq("R5", "clean err", 64'(e5), 0);
      @(negedge clk);
      check_eq("R6", "err holds clean", 64'(e5), 0);
      do_clr();
      fr = 64'b101000110101110 ^ 64'b000010000000000;
      send(0, fr, 15, 1'b1, 0, 0, 99);
      check_eq("R5", "bad rem", 64'(r5), 64'(mod2rem(fr, 15, 5, 17'h35)));
      check_eq("R5", "bad err", 64'(e5), 1);
      repeat (2) @(negedge clk);
      check_eq("R6", "err sticky", 64'(e5), 1);

      // R2 partial frame and idle cycles
      do_clr();
      send(0, 64'b110111, 6, 1'b1, 0, 0, 99);
      exp = mod2rem(64'b110111, 6, 5, 17'h35);
      check_eq("R2", "partial rem", 64'(r5), 64'(exp));
      repeat (5) begin bitin = 1'($urandom); @(negedge clk); end
      check_eq("R2", "idle holds", 64'(r5), 64'(exp));
      // R1 clr wins over a qualified bit
      v5 = 1'b1; bitin = 1'b1; clr = 1'b1; @(negedge clk);
      v5 = 1'b0; clr = 1'b0;
      check_eq("R1", "clr over valid", 64'(r5), 0);

      // R8 four-bit divisor
      do_clr();
      send(1, 64'b00111011001 << 4, 15, 1'b0, 0, 1, 11);
      check_eq("R8", "fcs 11001", 64'(r4), 64'b0100);
      for (int b = 0; b < 15; b++) begin
         do_clr();
         fr = 64'b001110110010100 ^ (64'd1 << b);
         send(1, fr, 15, 1'b1, 0, 0, 99);
         check_eq("R8", "flip rem", 64'(r4 != 0), 1);
         check_eq("R8", "flip err", 64'(e4), 1);
      end

      // Random frames on the 5-bit and 16-bit instances
      for (int t = 0; t < 24; t++) begin
         int u = (t % 2 == 0) ? 0 : 2;
         int w = (u == 0) ? 5 : 16;
         int k = (u == 0) ? 10 : 24;
         logic [16:0] pf = (u == 0) ? 17'h35 : 17'h11021;
         logic [63:0] msg = {$urandom, $urandom} & ((64'd1 << k) - 1);
         string rq = (u == 0) ? "R3" : "R9";
         do_clr();
         send(u, msg << w, k + w, 1'b0, 1, 1, k);
         exp = mod2rem(msg << w, k + w, w, pf);
         check_eq(rq, "random gen", 64'(get_rem(u)), 64'(exp));
         check_eq("R6", "random done", 64'(get_done(u)), 1);
         fr = (msg << w) | 64'(exp);
         if ($urandom % 2 == 0) fr = fr ^ (64'd1 << ($urandom % (k + w)));
         do_clr();
         send(u, fr, k + w, 1'b1, 1, 0, 99);
         exp = mod2rem(fr, k + w, w, pf);
         check_eq((u == 0) ? "R5" : "R9", "random chk", 64'(get_rem(u)), 64'(exp));
         check_eq("R5", "random err", 64'(get_err(u)), 64'(exp != 0));
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule